// File: doc/BRIEF.md
# Video Capture Burst Write Processor

This block sits between a video decoder and a memory arbiter. The decoder runs on its own clock and produces 32-bit pixel-pair words together with one-cycle timing flags. In the decoder clock domain, the block follows those flags to know which line and which pixel pair each word belongs to. It puts the two luma and two chroma bytes into display order and pushes every accepted word into an external dual-clock FIFO. Each word goes in tagged with its line number and its burst index.

In the system clock domain, the block watches the read-side word count of the FIFO. Once a full burst of eight words is waiting, it raises a write request toward the arbiter. The 24-bit address of that request is built from the tag of the oldest word. The arbiter then pops the eight words one at a time. The block forwards each pop to the FIFO and shows the head word on its memory data output. Because the line and burst values travel through the FIFO with the data, the write address always describes the words actually being written, even though the request is formed in the other clock domain.

Top module: `capture_burst_writer`

## Requirements
- R1: Each accepted decoder word is stored with its bytes in reverse order. Input bits [31:24] Cb, [23:16] left luma, [15:8] Cr and [7:0] right luma become entry bits [7:0], [15:8], [23:16] and [31:24] respectively. A FIFO entry is {line[46:38], burst index[37:32], word[31:0]}.
- R2: A word is written only when the valid flag is high in a cycle strictly after a start-of-active-video flag and before the next end-of-active-video flag. Words in a flag cycle, or with valid low, are not written.
- R3: A word that would be written while the FIFO reports full is not written, and it sets a sticky overflow flag. Only the decoder-domain reset clears that flag, and a start of field does not.
- R4: A start-of-even-field or start-of-odd-field flag resets the line counter to 0. Each end-of-active-video flag advances it by one, and it holds at 506.
- R5: The burst index of a word is its pixel-pair position in the line divided by 8. The position restarts at 0 on each start-of-active-video flag. Words beyond the 360th pair of a line are discarded.
- R6: After an idle system clock edge at which the read-side count is at least 8, the write request is high from that edge on. It stays low while fewer than 8 words wait.
- R7: The write address is {2'b00 bank, 4'b0000, line[8:0], burst index[5:0], 3'b000}, taken from the head entry when the request rises. It stays unchanged until the burst completes.
- R8: A pop from the arbiter reaches the FIFO read enable only while a request or burst is in progress. The request drops after the first pop, and the block returns to idle after the eighth pop. Pops while idle do nothing.
- R9: The memory write data output always equals the data word of the FIFO head entry.
- R10: After reset, no request is raised, no FIFO write or read is issued, and the overflow flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_clk | input | 1 | Decoder clock |
| dec_rst | input | 1 | Synchronous reset, decoder domain, active high |
| dec_field_even | input | 1 | Start of even field pulse |
| dec_field_odd | input | 1 | Start of odd field pulse |
| dec_sav | input | 1 | Start of active video pulse |
| dec_eav | input | 1 | End of active video pulse |
| dec_valid | input | 1 | Decoder data qualifier |
| dec_data | input | 32 | Decoder pixel-pair word (Cb, Y, Cr, Y) |
| fifo_full | input | 1 | FIFO write-side full |
| fifo_wr_en | output | 1 | FIFO write enable |
| fifo_wr_data | output | 47 | Tagged entry: line, burst index, reordered word |
| overflow | output | 1 | Sticky dropped-word flag |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous reset, system domain, active high |
| fifo_rd_count | input | 6 | FIFO read-side word count |
| fifo_rd_data | input | 47 | FIFO head entry (show-ahead) |
| arb_pop | input | 1 | Arbiter request for the next burst word |
| fifo_rd_en | output | 1 | FIFO read enable |
| wr_req | output | 1 | Burst write request to the arbiter |
| wr_addr | output | 24 | Bank, row, column address of the burst |
| mem_wdata | output | 32 | Word handed to memory for the current beat |

## Verification
The assertions check, on every cycle, the rules that can be stated locally. No write happens into a full FIFO, the overflow flag stays set once set, and no write is made from a flag cycle or a cycle with valid low. On the system side they check that a request rises only above a full burst of count, that the address is aligned and held through the burst, that the request drops after its first pop, and that no read happens on an empty FIFO. Only the bench scenarios can show that the stored bytes, line numbers and burst indices are the right ones for a sequence of flags. The same holds for the line clamp at 506, the 360-pair cut-off, the addresses of successive bursts that straddle a line boundary, and the clearing of overflow by reset alone.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 9;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;

  typedef enum logic [1:0] {
    RQ_IDLE  = 2'd0,
    RQ_OFFER = 2'd1,
    RQ_MOVE  = 2'd2
  } rq_state_e;

  // Reverse the byte lanes: decoder order to display order.
  function automatic logic [WORD_W-1:0] reverse_lanes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W / LANE_W; i++) begin
      r[i*LANE_W +: LANE_W] = w[WORD_W - LANE_W - i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  // Bank fixed at zero, row is the padded line, column is the burst index scaled by burst length.
  function automatic logic [ADDR_W-1:0] burst_address(input logic [ROW_W-1:0] row,
                                                      input logic [COL_W-1:0] bidx,
                                                      input int shift);
    logic [COL_W-1:0] col;
    col = bidx << shift;
    return {{BANK_W{1'b0}}, row, col};
  endfunction
endpackage

// File: rtl/cbw_capture.sv
module cbw_capture
  import cbw_pkg::*;
#(
  parameter int LINES     = 507,
  parameter int PAIRS     = 360,
  parameter int BURST_LEN = 8,
  localparam int LINE_W   = $clog2(LINES),
  localparam int PAIR_W   = $clog2(PAIRS + 1),
  localparam int BSHIFT   = $clog2(BURST_LEN),
  localparam int BIDX_W   = PAIR_W - BSHIFT,
  localparam int ENTRY_W  = WORD_W + LINE_W + BIDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               field_even,
  input  logic               field_odd,
  input  logic               sav,
  input  logic               eav,
  input  logic               valid,
  input  logic [WORD_W-1:0]  data,
  input  logic               fifo_full,
  output logic               fifo_wr_en,
  output logic [ENTRY_W-1:0] fifo_wr_data,
  output logic               overflow,
  output logic               take_o,
  output logic               drop_o
);
  logic [LINE_W-1:0] line_q;
  logic [PAIR_W-1:0] pair_q;
  logic              active_q;
  logic              ovf_q;
  logic              field_start, in_window, has_room, take, drop;

  always_comb begin
    field_start = field_even | field_odd;
    in_window   = active_q & ~sav & ~eav & ~field_start;
    has_room    = pair_q < PAIR_W'(PAIRS);
    take        = valid & in_window & has_room;
    drop        = take & fifo_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '0;
      pair_q   <= '0;
      active_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= ovf_q | drop;
      if (field_start) begin
        line_q   <= '0;
        pair_q   <= '0;
        active_q <= 1'b0;
      end else begin
        if (eav) begin
          active_q <= 1'b0;
          if (line_q != LINE_W'(LINES - 1)) line_q <= line_q + 1'b1;
        end
        if (sav) begin
          active_q <= 1'b1;
          pair_q   <= '0;
        end else if (take) begin
          pair_q <= pair_q + 1'b1;
        end
      end
    end
  end

  assign fifo_wr_en   = take & ~fifo_full;
  assign fifo_wr_data = {line_q, pair_q[PAIR_W-1:BSHIFT], reverse_lanes(data)};
  assign overflow     = ovf_q;
  assign take_o       = take;
  assign drop_o       = drop;
endmodule

// File: rtl/cbw_requester.sv
module cbw_requester
  import cbw_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 6,
  parameter int LINE_W    = 9,
  parameter int BIDX_W    = 6,
  localparam int BSHIFT   = $clog2(BURST_LEN),
  localparam int ENTRY_W  = WORD_W + LINE_W + BIDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   fifo_rd_count,
  input  logic [ENTRY_W-1:0] fifo_rd_data,
  input  logic               arb_pop,
  output logic               fifo_rd_en,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  output logic               busy_o
);
  rq_state_e         state_q;
  logic [BSHIFT-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] head_line;
  logic [BIDX_W-1:0] head_bidx;
  logic              burst_ready, pop_ok, last_beat;

  always_comb begin
    head_line   = fifo_rd_data[ENTRY_W-1 -: LINE_W];
    head_bidx   = fifo_rd_data[WORD_W +: BIDX_W];
    burst_ready = fifo_rd_count >= CNT_W'(BURST_LEN);
    pop_ok      = arb_pop & (state_q != RQ_IDLE);
    last_beat   = pop_ok & (beat_q == BSHIFT'(BURST_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RQ_IDLE;
      beat_q  <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        RQ_IDLE: if (burst_ready) begin
          state_q <= RQ_OFFER;
          beat_q  <= '0;
          addr_q  <= burst_address(ROW_W'(head_line), COL_W'(head_bidx), BSHIFT);
        end
        RQ_OFFER: if (pop_ok) begin
          state_q <= last_beat ? RQ_IDLE : RQ_MOVE;
          beat_q  <= beat_q + 1'b1;
        end
        RQ_MOVE: if (pop_ok) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= RQ_IDLE;
        end
        default: state_q <= RQ_IDLE;
      endcase
    end
  end

  assign fifo_rd_en = pop_ok;
  assign wr_req     = (state_q == RQ_OFFER);
  assign wr_addr    = addr_q;
  assign mem_wdata  = fifo_rd_data[WORD_W-1:0];
  assign busy_o     = (state_q != RQ_IDLE);
endmodule

// File: rtl/capture_burst_writer.sv
module capture_burst_writer
  import cbw_pkg::*;
#(
  parameter int LINES     = 507,
  parameter int PAIRS     = 360,
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 6,
  localparam int LINE_W   = $clog2(LINES),
  localparam int PAIR_W   = $clog2(PAIRS + 1),
  localparam int BIDX_W   = PAIR_W - $clog2(BURST_LEN),
  localparam int ENTRY_W  = WORD_W + LINE_W + BIDX_W
) (
  input  logic               dec_clk,
  input  logic               dec_rst,
  input  logic               dec_field_even,
  input  logic               dec_field_odd,
  input  logic               dec_sav,
  input  logic               dec_eav,
  input  logic               dec_valid,
  input  logic [WORD_W-1:0]  dec_data,
  input  logic               fifo_full,
  output logic               fifo_wr_en,
  output logic [ENTRY_W-1:0] fifo_wr_data,
  output logic               overflow,
  input  logic               sys_clk,
  input  logic               sys_rst,
  input  logic [CNT_W-1:0]   fifo_rd_count,
  input  logic [ENTRY_W-1:0] fifo_rd_data,
  input  logic               arb_pop,
  output logic               fifo_rd_en,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  mem_wdata
);
  // Named internal events, observed by the bound checker.
  logic cap_take;
  logic cap_drop;
  logic rq_busy;

  cbw_capture #(.LINES(LINES), .PAIRS(PAIRS), .BURST_LEN(BURST_LEN)) u_capture (
    .clk          (dec_clk),
    .rst          (dec_rst),
    .field_even   (dec_field_even),
    .field_odd    (dec_field_odd),
    .sav          (dec_sav),
    .eav          (dec_eav),
    .valid        (dec_valid),
    .data         (dec_data),
    .fifo_full    (fifo_full),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .overflow     (overflow),
    .take_o       (cap_take),
    .drop_o       (cap_drop)
  );

  cbw_requester #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .LINE_W(LINE_W), .BIDX_W(BIDX_W)) u_requester (
    .clk           (sys_clk),
    .rst           (sys_rst),
    .fifo_rd_count (fifo_rd_count),
    .fifo_rd_data  (fifo_rd_data),
    .arb_pop       (arb_pop),
    .fifo_rd_en    (fifo_rd_en),
    .wr_req        (wr_req),
    .wr_addr       (wr_addr),
    .mem_wdata     (mem_wdata),
    .busy_o        (rq_busy)
  );
endmodule

// File: rtl/cbw_checker.sv
module cbw_checker #(
  parameter int BURST_LEN = 8,
  parameter int CNT_W     = 6,
  parameter int ADDR_W    = 24
) (
  input logic              dec_clk,
  input logic              dec_rst,
  input logic              dec_valid,
  input logic              dec_sav,
  input logic              dec_eav,
  input logic              fifo_full,
  input logic              fifo_wr_en,
  input logic              overflow,
  input logic              cap_take,
  input logic              cap_drop,
  input logic              sys_clk,
  input logic              sys_rst,
  input logic [CNT_W-1:0]  fifo_rd_count,
  input logic              fifo_rd_en,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rq_busy
);
  localparam int BSHIFT = $clog2(BURST_LEN);

  p_no_write_when_full_r3: assert property (@(posedge dec_clk) disable iff (dec_rst)
    fifo_full |-> !fifo_wr_en);

  p_overflow_sticky_r3: assert property (@(posedge dec_clk) disable iff (dec_rst)
    overflow |=> overflow);

  p_drop_sets_overflow_r3: assert property (@(posedge dec_clk) disable iff (dec_rst)
    cap_drop |=> overflow);

  p_write_in_window_r2: assert property (@(posedge dec_clk) disable iff (dec_rst)
    fifo_wr_en |-> (dec_valid && !dec_sav && !dec_eav && cap_take));

  p_req_needs_burst_r6: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $rose(wr_req) |-> ($past(fifo_rd_count) >= CNT_W'(BURST_LEN)));

  p_addr_aligned_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    wr_req |-> (wr_addr[BSHIFT-1:0] == '0 && wr_addr[ADDR_W-1 -: 2] == 2'b00));

  p_addr_held_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    rq_busy |=> (!rq_busy || $stable(wr_addr)));

  p_req_drops_on_pop_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (wr_req && fifo_rd_en) |=> !wr_req);

  p_no_underflow_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    fifo_rd_en |-> (fifo_rd_count != '0));
endmodule

bind capture_burst_writer cbw_checker #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W), .ADDR_W(cbw_pkg::ADDR_W)) u_cbw_checker (
  .dec_clk       (dec_clk),
  .dec_rst       (dec_rst),
  .dec_valid     (dec_valid),
  .dec_sav       (dec_sav),
  .dec_eav       (dec_eav),
  .fifo_full     (fifo_full),
  .fifo_wr_en    (fifo_wr_en),
  .overflow      (overflow),
  .cap_take      (cap_take),
  .cap_drop      (cap_drop),
  .sys_clk       (sys_clk),
  .sys_rst       (sys_rst),
  .fifo_rd_count (fifo_rd_count),
  .fifo_rd_en    (fifo_rd_en),
  .wr_req        (wr_req),
  .wr_addr       (wr_addr),
  .rq_busy       (rq_busy)
);

// File: tb/tb_capture_burst_writer.sv
module tb_capture_burst_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DEC_PERIOD = 40;
  localparam int DEPTH      = 32;
  localparam int LOG_N      = 1024;
  localparam logic [63:0] VEC [6] = '{
    64'h11223344_44332211,
    64'h80108010_10801080,
    64'hA1B2C3D4_D4C3B2A1,
    64'h00FF00FF_FF00FF00,
    64'h12345678_78563412,
    64'hF0E1D2C3_C3D2E1F0
  };

  logic        dec_clk = 1'b0, sys_clk = 1'b0;
  logic        dec_rst, sys_rst;
  logic        dec_field_even = 0, dec_field_odd = 0, dec_sav = 0, dec_eav = 0, dec_valid = 0;
  logic [31:0] dec_data = '0;
  logic        fifo_full, fifo_wr_en, overflow, fifo_rd_en, wr_req, arb_pop;
  logic [46:0] fifo_wr_data, fifo_rd_data;
  logic [5:0]  fifo_rd_count;
  logic [23:0] wr_addr;
  logic [31:0] mem_wdata;

  int n_checks = 0, n_err = 0;

  capture_burst_writer dut (
    .dec_clk(dec_clk), .dec_rst(dec_rst), .dec_field_even(dec_field_even),
    .dec_field_odd(dec_field_odd), .dec_sav(dec_sav), .dec_eav(dec_eav),
    .dec_valid(dec_valid), .dec_data(dec_data), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .overflow(overflow),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .fifo_rd_count(fifo_rd_count),
    .fifo_rd_data(fifo_rd_data), .arb_pop(arb_pop), .fifo_rd_en(fifo_rd_en),
    .wr_req(wr_req), .wr_addr(wr_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #(DEC_PERIOD/2) dec_clk = ~dec_clk;

  // Dual-clock FIFO model: a log of every write, read through a pointer.
  logic [46:0] log_mem [LOG_N];
  int wp = 0, rp = 0;
  logic flush = 1'b0;
  int fill;
  assign fill          = wp - rp;
  assign fifo_full     = (fill >= DEPTH);
  assign fifo_rd_count = 6'(fill);
  assign fifo_rd_data  = log_mem[rp % LOG_N];

  always @(posedge dec_clk) if (fifo_wr_en) begin
    log_mem[wp % LOG_N] <= fifo_wr_data;
    wp <= wp + 1;
  end
  always @(posedge sys_clk) begin
    if (flush) rp <= wp;
    else if (fifo_rd_en) rp <= rp + 1;
  end

  // Arbiter model: manual pops from tasks, or an automatic drainer.
  logic man_pop = 1'b0, auto_pop = 1'b0, auto_on = 1'b0;
  int drain_left = 0;
  assign arb_pop = man_pop | auto_pop;
  always @(negedge sys_clk) begin
    if (!auto_on) begin
      auto_pop <= 1'b0; drain_left <= 0;
    end else if (drain_left != 0) begin
      auto_pop <= 1'b1; drain_left <= drain_left - 1;
    end else if (wr_req && !auto_pop) begin
      auto_pop <= 1'b1; drain_left <= 7;
    end else begin
      auto_pop <= 1'b0;
    end
  end

  // Expected entries, indexed by absolute write number.
  logic [31:0] ex_word [LOG_N];
  logic [8:0]  ex_line [LOG_N];
  logic [5:0]  ex_bidx [LOG_N];
  int ex_n = 0;

  function automatic logic [31:0] tb_swap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dec_cyc(input logic fe, input logic fo, input logic s, input logic e,
                         input logic v, input logic [31:0] d);
    @(negedge dec_clk);
    dec_field_even = fe; dec_field_odd = fo; dec_sav = s; dec_eav = e;
    dec_valid = v; dec_data = d;
  endtask

  task automatic send_word(input logic [31:0] d, input int line, input int pair);
    dec_cyc(0, 0, 0, 0, 1, d);
    ex_word[ex_n % LOG_N] = tb_swap(d);
    ex_line[ex_n % LOG_N] = 9'(line);
    ex_bidx[ex_n % LOG_N] = 6'(pair / 8);
    ex_n++;
  endtask

  task automatic check_entry(input int idx, input string tag);
    logic [46:0] exp;
    exp = {ex_line[idx % LOG_N], ex_bidx[idx % LOG_N], ex_word[idx % LOG_N]};
    check(log_mem[idx % LOG_N] == exp, tag, 64'(log_mem[idx % LOG_N]), 64'(exp));
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic run_burst(input logic [23:0] exp_addr, input string tag);
    int guard = 0;
    int rp0;
    @(negedge sys_clk);
    while (!wr_req && guard < 200) begin @(negedge sys_clk); guard++; end
    check(wr_req, {tag, " R6 request raised"}, 64'(wr_req), 64'd1);
    check(wr_addr == exp_addr, {tag, " R7 address"}, 64'(wr_addr), 64'(exp_addr));
    rp0 = rp;
    for (int b = 0; b < 8; b++) begin
      check(mem_wdata == ex_word[rp % LOG_N], {tag, " R9 beat data"}, 64'(mem_wdata), 64'(ex_word[rp % LOG_N]));
      man_pop = 1'b1;
      @(negedge sys_clk);
      if (b == 0) check(!wr_req, {tag, " R8 request drops after first pop"}, 64'(wr_req), 64'd0);
    end
    man_pop = 1'b0;
    check(rp == rp0 + 8, {tag, " R8 eight words popped"}, 64'(rp - rp0), 64'd8);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge sys_clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    int wp0;
    dec_rst = 1'b1; sys_rst = 1'b1;
    repeat (3) @(negedge dec_clk);
    dec_rst = 1'b0;
    @(negedge sys_clk); sys_rst = 1'b0;
    sys_wait(2);

    // R10: reset state, and a pop while idle is not forwarded
    check(!wr_req, "R10 no request after reset", 64'(wr_req), 64'd0);
    check(!overflow, "R10 overflow low after reset", 64'(overflow), 64'd0);
    check(!fifo_wr_en, "R10 no FIFO write after reset", 64'(fifo_wr_en), 64'd0);
    man_pop = 1'b1; #1;
    check(!fifo_rd_en, "R10 R8 idle pop not forwarded", 64'(fifo_rd_en), 64'd0);
    @(negedge sys_clk); man_pop = 1'b0;

    // Table walk on line 0: byte order, tags, gap with valid low
    dec_cyc(1, 0, 0, 0, 0, '0);
    dec_cyc(0, 0, 1, 0, 0, '0);
    for (int i = 0; i < 6; i++) begin
      send_word(VEC[i][63:32], 0, i);
      if (i == 2) dec_cyc(0, 0, 0, 0, 0, 32'hDEADBEEF);
    end
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 0, 0, 0, '0);
    sys_wait(6);
    check(wp == 6, "R2 valid-low word not written", 64'(wp), 64'd6);
    for (int i = 0; i < 6; i++) begin
      check(log_mem[i][31:0] == VEC[i][31:0], "R1 byte reorder", 64'(log_mem[i][31:0]), 64'(VEC[i][31:0]));
      check(log_mem[i][46:32] == 15'd0, "R4 R5 line 0 burst 0 tag", 64'(log_mem[i][46:32]), 64'd0);
    end
    check(!wr_req, "R6 no request below a burst", 64'(wr_req), 64'd0);

    // Line 1: valid words in the flag cycles are ignored, 18 words cross a burst boundary
    dec_cyc(0, 0, 1, 0, 1, 32'hBAD0BAD0);
    for (int k = 0; k < 18; k++) send_word(32'h1000_0000 + 32'(k), 1, k);
    dec_cyc(0, 0, 0, 1, 1, 32'hBAD1BAD1);
    dec_cyc(0, 0, 0, 0, 0, '0);
    sys_wait(4);
    check(wp == 24, "R2 flag-cycle words not written", 64'(wp), 64'd24);
    for (int i = 6; i < 24; i++) check_entry(i, "R4 R5 line 1 tags");
    check(wr_req, "R6 request raised at a full burst", 64'(wr_req), 64'd1);
    sys_wait(3);
    check(wr_req && wr_addr == 24'h0, "R7 request and address held", 64'(wr_addr), 64'h0);

    // Three bursts: heads are line 0 burst 0, line 1 burst 0, line 1 burst 1
    run_burst(24'h000000, "burst A");
    run_burst(24'h000200, "burst B");
    run_burst(24'h000208, "burst C");
    sys_wait(4);
    check(!wr_req, "R6 no request on empty FIFO", 64'(wr_req), 64'd0);
    man_pop = 1'b1;
    sys_wait(2);
    man_pop = 1'b0;
    check(rp == 24, "R8 pops while idle ignored", 64'(rp), 64'd24);

    // Odd field start resets the line counter
    dec_cyc(0, 1, 0, 0, 0, '0);
    dec_cyc(0, 0, 1, 0, 0, '0);
    for (int k = 0; k < 8; k++) send_word(32'h2000_0000 + 32'(k), 0, k);
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 0, 0, 0, '0);
    run_burst(24'h000000, "odd field R4");

    // Line clamp at 506
    for (int k = 0; k < 510; k++) dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 1, 0, 0, '0);
    send_word(32'h3000_0001, 506, 0);
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 1, 0, 0, '0);
    send_word(32'h3000_0002, 506, 0);
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(1, 0, 0, 0, 0, '0);
    dec_cyc(0, 0, 0, 0, 0, '0);
    check(log_mem[(wp-2) % LOG_N][46:38] == 9'd506, "R4 line clamps at 506", 64'(log_mem[(wp-2) % LOG_N][46:38]), 64'd506);
    check(log_mem[(wp-1) % LOG_N][46:38] == 9'd506, "R4 line holds at 506", 64'(log_mem[(wp-1) % LOG_N][46:38]), 64'd506);
    @(negedge sys_clk); flush = 1'b1;
    @(negedge sys_clk); flush = 1'b0;
    sys_wait(2);

    // Full line of 362 words with the drainer running: only 360 stored
    auto_on = 1'b1;
    wp0 = wp;
    dec_cyc(0, 0, 1, 0, 0, '0);
    for (int k = 0; k < 360; k++) send_word(32'h4000_0000 + 32'(k), 0, k);
    dec_cyc(0, 0, 0, 0, 1, 32'h4FFF_0001);
    dec_cyc(0, 0, 0, 0, 1, 32'h4FFF_0002);
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 0, 0, 0, '0);
    sys_wait(60);
    check(wp - wp0 == 360, "R5 words past pair 360 discarded", 64'(wp - wp0), 64'd360);
    check(log_mem[(wp-1) % LOG_N][37:32] == 6'd44, "R5 last burst index 44", 64'(log_mem[(wp-1) % LOG_N][37:32]), 64'd44);
    check_entry(wp - 1, "R1 R5 last entry of line");
    check(fill == 0, "R8 drainer emptied the FIFO", 64'(fill), 64'd0);
    check(!overflow, "R3 no overflow while draining", 64'(overflow), 64'd0);
    auto_on = 1'b0;
    sys_wait(4);

    // Overflow: 34 words into an undrained FIFO of 32
    wp0 = wp;
    dec_cyc(0, 0, 1, 0, 0, '0);
    for (int k = 0; k < 32; k++) send_word(32'h5000_0000 + 32'(k), 0, k);
    dec_cyc(0, 0, 0, 0, 1, 32'h5FFF_0001);
    dec_cyc(0, 0, 0, 0, 1, 32'h5FFF_0002);
    dec_cyc(0, 0, 0, 1, 0, '0);
    dec_cyc(0, 0, 0, 0, 0, '0);
    check(wp - wp0 == 32, "R3 no write while full", 64'(wp - wp0), 64'd32);
    check(overflow, "R3 overflow set on drop", 64'(overflow), 64'd1);
    dec_cyc(0, 1, 0, 0, 0, '0);
    repeat (4) dec_cyc(0, 0, 0, 0, 0, '0);
    check(overflow, "R3 overflow sticky across field start", 64'(overflow), 64'd1);
    @(negedge dec_clk); dec_rst = 1'b1;
    @(negedge dec_clk); dec_rst = 1'b0;
    check(!overflow, "R3 overflow cleared by reset", 64'(overflow), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule